// File: doc/BRIEF.md
# Framed Serial Load Receiver for a Dual-Channel DAC

This block receives command words for a two-channel digital-to-analog converter over a three-wire serial link: an active-low frame strobe, a serial clock and a serial data line. All three inputs are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and the block then finds the edges in the system clock domain.

A frame opens when the strobe falls. The block samples one data bit on each falling edge of the serial clock, most significant bit first. The word takes effect on the sixteenth falling edge, whether or not the strobe has risen. If the strobe rises before that edge, the partial word is dropped and no register changes.

A completed word names one channel, the other channel or both. It carries an 8-bit code and one of three actions: load only, load and update, or power down. Each channel has a hidden input register and a visible output register. A load-and-update copies both input registers to the outputs and raises a one-cycle update pulse.

Top module: `dual_dac_serial_rx`

## Requirements
- R1: While reset is low, and after its release with no frame sent, both channel outputs read zero, both power-down flags read 0 and the update pulse reads 0.
- R2: A frame opens only on a falling edge of the frame strobe. While the strobe stays low, each falling edge of the serial clock shifts in one data bit, most significant first, so the first bit lands in word bit 15.
- R3: The word is applied on the sixteenth falling serial clock edge of the frame. The strobe does not need to rise for this to happen.
- R4: If the strobe rises after fewer than sixteen falling edges, the frame is discarded. No output, input register or power-down flag changes, and no update pulse is raised.
- R5: After sixteen edges, further falling serial clock edges are ignored until the strobe goes high and then low again. The next frame is then received normally.
- R6: Word layout. Bit 15 selects channel A and bit 14 selects channel B; both set selects both, and neither set selects none. Bits 13:12 are the action: 00 load only, 01 load and update, 10 power down, 11 no effect. Bits 11:4 are the 8-bit code. Bits 3:0 are ignored.
- R7: Load only writes the code into the input register of each selected channel. It leaves the outputs unchanged and raises no update pulse.
- R8: Load and update writes the code into the selected input registers. It then copies both input registers to the outputs, clears the power-down flag of each selected channel and raises the update pulse.
- R9: Power down sets the power-down flag of each selected channel. It stores no code, leaves the outputs unchanged and raises no update pulse.
- R10: The update pulse lasts exactly one system clock cycle. Channel outputs change only in the cycle in which the pulse is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_n | input | 1 | Active-low frame strobe, asynchronous |
| sclk | input | 1 | Serial clock; data is taken on its falling edges, asynchronous |
| sdata | input | 1 | Serial data, most significant bit first, asynchronous |
| dac_a | output | 8 | Channel A output register |
| dac_b | output | 8 | Channel B output register |
| pd_a | output | 1 | Channel A power-down flag |
| pd_b | output | 1 | Channel B power-down flag |
| upd | output | 1 | One-cycle pulse when a word is applied to the outputs |

## Verification
The assertions check several rules on every cycle:
- The bit count never goes past sixteen, and it stays frozen after a full word until the strobe rises.
- A rising strobe is never followed by an output change or an update pulse.
- The update pulse is never two cycles wide, and outputs move only together with it.
- A power-down flag never rises alongside an update.

Only the bench scenarios can show that bits arrive most significant first and that each action and channel-select combination has the right effect. They also show that truncated frames of every length from zero to fifteen bits leave all state alone, and that trailing clock edges are ignored. The bench compares against a register model computed from the word fields.

// File: rtl/dual_dac_serial_rx.sv
module dual_dac_serial_rx #(
  parameter int WORD_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic              sclk,
  input  logic              sdata,
  output logic [DATA_W-1:0] dac_a,
  output logic [DATA_W-1:0] dac_b,
  output logic              pd_a,
  output logic              pd_b,
  output logic              upd
);

  localparam int CW = $clog2(WORD_W + 1);
  localparam int SEL_A = WORD_W - 1;
  localparam int SEL_B = WORD_W - 2;
  localparam int ACT_LO = WORD_W - 4;
  localparam int DAT_LO = WORD_W - 4 - DATA_W;
  localparam logic [CW-1:0] FULL = CW'(WORD_W);
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);
  localparam logic [1:0] ACT_LOAD = 2'b00;
  localparam logic [1:0] ACT_UPD = 2'b01;
  localparam logic [1:0] ACT_PD = 2'b10;

  logic [2:0] sync_p, sclk_p;
  logic [1:0] din_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_p <= '1;
      sclk_p <= '1;
      din_p  <= '0;
    end else begin
      sync_p <= {sync_p[1:0], sync_n};
      sclk_p <= {sclk_p[1:0], sclk};
      din_p  <= {din_p[0], sdata};
    end
  end

  wire frame_open  = sync_p[2] & ~sync_p[1];
  wire frame_close = ~sync_p[2] & sync_p[1];
  wire sclk_fall   = sclk_p[2] & ~sclk_p[1];

  logic              active;
  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] shreg;
  logic [DATA_W-1:0] hold_a, hold_b;

  wire take = active & sclk_fall & ~sync_p[1] & (cnt < FULL);
  wire last = take & (cnt == LAST);
  wire [WORD_W-1:0] word = {shreg[WORD_W-2:0], din_p[1]};
  wire [1:0] act = word[ACT_LO +: 2];
  wire [DATA_W-1:0] code = word[DAT_LO +: DATA_W];
  wire wa = last & word[SEL_A];
  wire wb = last & word[SEL_B];
  wire loading = (act == ACT_LOAD) | (act == ACT_UPD);
  wire applying = last & (act == ACT_UPD);
  wire powering = last & (act == ACT_PD);
  wire [DATA_W-1:0] nxt_a = (wa & loading) ? code : hold_a;
  wire [DATA_W-1:0] nxt_b = (wb & loading) ? code : hold_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
    end else if (frame_close) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (frame_open) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (take) begin
      cnt   <= cnt + 1'b1;
      shreg <= word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_a <= '0;
      hold_b <= '0;
      dac_a  <= '0;
      dac_b  <= '0;
      pd_a   <= 1'b0;
      pd_b   <= 1'b0;
      upd    <= 1'b0;
    end else begin
      hold_a <= nxt_a;
      hold_b <= nxt_b;
      upd    <= applying;
      if (applying) begin
        dac_a <= nxt_a;
        dac_b <= nxt_b;
        if (wa) pd_a <= 1'b0;
        if (wb) pd_b <= 1'b0;
      end
      if (powering) begin
        if (wa) pd_a <= 1'b1;
        if (wb) pd_b <= 1'b1;
      end
    end
  end

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  assert_count_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL && !frame_close && !frame_open) |=> cnt == FULL);

  assert_abort_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_close |=> ($stable(dac_a) && $stable(dac_b) && !upd));

  assert_upd_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);

  assert_out_needs_upd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dac_a) || !$stable(dac_b)) |-> upd);

  assert_pd_no_upd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pd_a) || $rose(pd_b)) |-> !upd);

endmodule

// File: tb/dual_dac_serial_rx_test.sv
module dual_dac_serial_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 4;

  logic clk, rst_n, sync_n, sclk, sdata;
  logic [7:0] dac_a, dac_b;
  logic pd_a, pd_b, upd;

  dual_dac_serial_rx uut (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdata(sdata),
    .dac_a(dac_a), .dac_b(dac_b), .pd_a(pd_a), .pd_b(pd_b), .upd(upd)
  );

  int checks = 0, errors = 0, upd_cnt = 0, width_err = 0, m_upd = 0;
  logic upd_prev = 1'b0;
  logic finished = 1'b0;
  logic [7:0] m_in_a = 0, m_in_b = 0, m_out_a = 0, m_out_b = 0;
  logic m_pd_a = 0, m_pd_b = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (upd) upd_cnt++;
    if (upd && upd_prev) width_err++;
    upd_prev = upd;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input int extra);
    sync_n = 1'b0;
    wait_clk(HP);
    for (int i = 0; i < nbits + extra; i++) begin
      sdata = (i < 16) ? w[15-i] : ~w[0];
      sclk = 1'b1;
      wait_clk(HP);
      sclk = 1'b0;
      wait_clk(HP);
    end
    sclk = 1'b1;
    wait_clk(HP);
    sync_n = 1'b1;
    wait_clk(8);
  endtask

  task automatic model_apply(input logic [15:0] w);
    logic sa, sb;
    logic [1:0] m;
    logic [7:0] d;
    sa = w[15]; sb = w[14]; m = w[13:12]; d = w[11:4];
    if (m == 2'b00 || m == 2'b01) begin
      if (sa) m_in_a = d;
      if (sb) m_in_b = d;
    end
    if (m == 2'b01) begin
      m_out_a = m_in_a;
      m_out_b = m_in_b;
      if (sa) m_pd_a = 1'b0;
      if (sb) m_pd_b = 1'b0;
      m_upd = 1;
    end
    if (m == 2'b10) begin
      if (sa) m_pd_a = 1'b1;
      if (sb) m_pd_b = 1'b1;
    end
  endtask

  task automatic check_state(input string tag);
    check(tag, {14'd0, dac_a, dac_b, pd_a, pd_b}, {14'd0, m_out_a, m_out_b, m_pd_a, m_pd_b});
    check(tag, upd_cnt, m_upd);
  endtask

  task automatic frame(input logic [15:0] w, input string tag);
    upd_cnt = 0;
    m_upd = 0;
    send(w, 16, 0);
    model_apply(w);
    check_state(tag);
  endtask

  initial begin
    rst_n = 1'b0; sync_n = 1'b1; sclk = 1'b1; sdata = 1'b0;
    wait_clk(5);
    check("R1 in reset", {dac_a, dac_b, pd_a, pd_b, upd}, 19'd0);
    rst_n = 1'b1;
    wait_clk(5);
    check("R1 after release", {dac_a, dac_b, pd_a, pd_b, upd}, 19'd0);

    for (int sel = 0; sel < 4; sel++)
      for (int md = 0; md < 4; md++)
        for (int k = 0; k < 7; k++) begin
          logic [15:0] w;
          w = {2'(sel), 2'(md), 8'(k * 37 + 5), 4'(k * 3)};
          case (md)
            0: frame(w, "R7 load only");
            1: frame(w, "R8 load and update");
            2: frame(w, "R9 power down");
            default: frame(w, "R6 reserved action");
          endcase
        end

    for (int d = 0; d < 256; d++) begin
      logic [15:0] w;
      w = {2'((d % 3) + 1), 2'b01, 8'(d), 4'(d)};
      frame(w, "R2 R3 msb-first word commit");
    end

    for (int n = 0; n < 16; n++) begin
      logic [15:0] w;
      w = {2'b11, 2'b01, 8'(n * 16 + 7), 4'h0};
      upd_cnt = 0;
      m_upd = 0;
      send(w, n, 0);
      check_state("R4 short frame discarded");
    end
    frame({2'b11, 2'b10, 8'h00, 4'h0}, "R9 both down");
    for (int n = 1; n < 16; n += 7) begin
      upd_cnt = 0;
      m_upd = 0;
      send({2'b11, 2'b01, 8'hC3, 4'h0}, n, 0);
      check_state("R4 abort keeps power-down");
    end

    upd_cnt = 0;
    m_upd = 0;
    send({2'b11, 2'b01, 8'h5A, 4'h0}, 16, 5);
    model_apply({2'b11, 2'b01, 8'h5A, 4'h0});
    check_state("R5 trailing edges ignored");
    frame({2'b01, 2'b01, 8'hA5, 4'hF}, "R5 next frame accepted");

    check("R10 pulse width", width_err, 0);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule